// File: doc/BRIEF.md
# Fabric-wide bus lock arbiter

This block gives one master at a time exclusive use of a multi-master AHB-lite interconnect. Each master reports its lock request (its hmastlock), the transfer type it is presenting, the hready it sees, and whether it has a transfer in flight anywhere in the fabric. The block answers with a per-master stall, a per-master permission mask for the crossbar's request logic, and the index of the master that holds the lock.

A lock request waits until every other master has drained. While it waits, no other master may start a fresh NONSEQ transfer, so the drain is certain to end. When several masters ask in the same cycle, the lowest index wins. The owner then keeps every slave port to itself until it presents hmastlock low with hready high. A master in the middle of a burst, or one whose transfer a slave is waiting, keeps its path at all times. A stall is never raised on a master whose transfer is in flight.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After reset, with all inputs idle, `owner_vld` is 0, every `stall` bit is 0 and every `permit` bit is 1.
- R2: With no owner, when more than one master holds `lock_req`, the lowest-indexed one is the candidate and becomes the owner.
- R3: The candidate becomes owner at the clock edge that ends a cycle in which no other master has `inflight` high. Until that edge its `permit` is 0, and it is stalled while it presents NONSEQ.
- R4: While an owner holds the lock, the owner index stays constant. Every other master gets `permit` 0 unless R6 or R7 applies, and is stalled while it presents NONSEQ.
- R5: While a lock request is pending and there is no owner, every master that is not held by R6 or R7 gets `permit` 0 and is stalled on NONSEQ.
- R6: A master presenting BUSY (code 01) or SEQ (code 11) on its 2-bit `trans` field always has `permit` 1 and `stall` 0.
- R7: A master that in the previous cycle presented a non-IDLE transfer with `permit` 1 and `rdy` 0 has `permit` 1 and `stall` 0 in the current cycle.
- R8: `stall` is never 1 for a master whose `inflight` is 1.
- R9: When the owner presents `lock_req` low with `rdy` high, `owner_vld` falls at the next edge. A pending request is judged in the cycle after that.
- R10: A request from the highest-indexed master is granted once lower-indexed masters stop requesting.
- R11: The owner always has `permit` 1 and `stall` 0.
- R12: With no owner and no request pending, every master has `permit` 1 and `stall` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_req | input | N_MST | Per-master lock request |
| trans | input | 2*N_MST | Transfer type of master k in bits [2k+1:2k]: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| rdy | input | N_MST | hready as seen by each master |
| inflight | input | N_MST | Master has a transfer outstanding in the address or data phase |
| stall | output | N_MST | Force hready low on the master's address phase |
| permit | output | N_MST | Master may be routed to a slave |
| owner_idx | output | $clog2(N_MST) | Index of the lock owner |
| owner_vld | output | 1 | A master owns the lock |

## Verification
The bench builds the block with N_MST = 4. This lets three masters contend for the lock in one cycle, so the priority choice is tested against more than a simple pair. It also makes index 3 a true lowest-priority requester and exercises both bits of the owner index. With four masters, an owner, a candidate, a master mid-burst and a bystander can all be present in the same cycle.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;
    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;
endpackage

// File: rtl/lk_pick.sv
module lk_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  oh
);
    // lowest index wins: isolate lowest set bit
    assign any = |req;
    assign oh  = req & (~req + N'(1));

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lk_drain.sv
module lk_drain #(
    parameter int N = 4
) (
    input  logic [N-1:0] inflight,
    input  logic [N-1:0] cand_oh,
    output logic         drained
);
    // the candidate's own traffic does not block its grant
    assign drained = ((inflight & ~cand_oh) == '0);
endmodule

// File: rtl/lk_gate.sv
module lk_gate
    import bus_lock_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]   blocked,
    input  logic [2*N-1:0] trans,
    input  logic [N-1:0]   waited_q,
    input  logic [N-1:0]   inflight,
    input  logic [N-1:0]   rdy,
    output logic [N-1:0]   permit,
    output logic [N-1:0]   stall,
    output logic [N-1:0]   waited_d
);
    for (genvar g = 0; g < N; g++) begin : g_mst
        logic [1:0] tr;
        logic       hold;
        assign tr          = trans[2*g +: 2];
        // BUSY and SEQ share bit 0; a waited transfer must not change
        assign hold        = tr[0] | waited_q[g];
        assign permit[g]   = ~blocked[g] | hold;
        assign stall[g]    = ~permit[g] & (tr == TR_NSEQ) & ~inflight[g];
        assign waited_d[g] = (tr != TR_IDLE) & ~rdy[g] & permit[g];
    end
endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter #(
    parameter int N_MST = 4,
    localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MST-1:0]   lock_req,
    input  logic [2*N_MST-1:0] trans,
    input  logic [N_MST-1:0]   rdy,
    input  logic [N_MST-1:0]   inflight,
    output logic [N_MST-1:0]   stall,
    output logic [N_MST-1:0]   permit,
    output logic [IW-1:0]      owner_idx,
    output logic               owner_vld
);
    typedef struct packed {
        logic             vld;
        logic [IW-1:0]    own;
        logic [N_MST-1:0] waited;
    } st_t;

    st_t st_q, st_d;

    logic             cand_any;
    logic [IW-1:0]    cand_idx;
    logic [N_MST-1:0] cand_oh;
    logic             drained;
    logic             pend;
    logic [N_MST-1:0] own_oh;
    logic [N_MST-1:0] blocked;
    logic [N_MST-1:0] waited_nx;

    lk_pick #(.N(N_MST), .IW(IW)) u_pick (
        .req (lock_req),
        .any (cand_any),
        .idx (cand_idx),
        .oh  (cand_oh)
    );

    lk_drain #(.N(N_MST)) u_drain (
        .inflight (inflight),
        .cand_oh  (cand_oh),
        .drained  (drained)
    );

    assign pend    = cand_any & ~st_q.vld;
    assign own_oh  = N_MST'(1) << st_q.own;
    assign blocked = st_q.vld ? ~own_oh : {N_MST{pend}};

    lk_gate #(.N(N_MST)) u_gate (
        .blocked  (blocked),
        .trans    (trans),
        .waited_q (st_q.waited),
        .inflight (inflight),
        .rdy      (rdy),
        .permit   (permit),
        .stall    (stall),
        .waited_d (waited_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.waited = waited_nx;
        if (st_q.vld) begin
            if (((lock_req & own_oh) == '0) && ((rdy & own_oh) != '0)) begin
                st_d.vld = 1'b0;
            end
        end else if (pend && drained) begin
            st_d.vld = 1'b1;
            st_d.own = cand_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner_idx = st_q.own;
    assign owner_vld = st_q.vld;
endmodule

// File: rtl/lk_chk.sv
module lk_chk #(
    parameter int N_MST = 4,
    localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_MST-1:0]   lock_req,
    input logic [2*N_MST-1:0] trans,
    input logic [N_MST-1:0]   rdy,
    input logic [N_MST-1:0]   inflight,
    input logic [N_MST-1:0]   stall,
    input logic [N_MST-1:0]   permit,
    input logic [IW-1:0]      owner_idx,
    input logic               owner_vld
);
    logic [N_MST-1:0] own_oh;
    assign own_oh = N_MST'(1) << owner_idx;

    // R11
    owner_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_vld |-> ((permit & own_oh) != '0) && ((stall & own_oh) == '0));

    // R3
    drained_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner_vld) |-> (($past(inflight) & ~own_oh) == '0));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld && ((lock_req & own_oh) == '0) && ((rdy & own_oh) != '0))
        |=> !owner_vld);

    // R4
    owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld && $past(owner_vld)) |-> (owner_idx == $past(owner_idx)));

    for (genvar k = 0; k < N_MST; k++) begin : g_burst
        // R6
        burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trans[2*k] |-> (permit[k] && !stall[k]));
    end
endmodule

bind bus_lock_arbiter lk_chk #(.N_MST(N_MST)) u_chk (.*);

// File: tb/test_bus_lock_arbiter.sv
`timescale 1ns/1ps
module test_bus_lock_arbiter;
    localparam int N = 4;
    localparam int NV = 26;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   lock_req = '0;
    logic [2*N-1:0] trans = '0;
    logic [N-1:0]   rdy = '1;
    logic [N-1:0]   inflight = '0;
    logic [N-1:0]   stall, permit;
    logic [1:0]     owner_idx;
    logic           owner_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_lock_arbiter #(.N_MST(N)) i_bus_lock_arbiter (
        .clk, .rst_n, .lock_req, .trans, .rdy, .inflight,
        .stall, .permit, .owner_idx, .owner_vld
    );

    // {lock, trans, rdy, inflight, exp_stall, exp_permit, exp_vld, exp_idx}
    // trans: 2 bits per master, 00 IDLE 01 BUSY 10 NONSEQ 11 SEQ
    localparam logic [30:0] VEC [NV] = '{
        {4'b0000, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b0, 2'd0}, // 0 R12
        {4'b0000, 8'hAA, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b0, 2'd0}, // 1 R12
        {4'b0100, 8'h2B, 4'b1111, 4'b0001, 4'b0110, 4'b0001, 1'b0, 2'd0}, // 2 R3 R5 R6
        {4'b0100, 8'h28, 4'b1111, 4'b0000, 4'b0110, 4'b0000, 1'b0, 2'd0}, // 3 R3
        {4'b0100, 8'h28, 4'b1111, 4'b0000, 4'b0010, 4'b0100, 1'b1, 2'd2}, // 4 R4 R11
        {4'b0101, 8'h22, 4'b1111, 4'b0100, 4'b0001, 4'b0100, 1'b1, 2'd2}, // 5 R4
        {4'b0001, 8'h22, 4'b1111, 4'b0100, 4'b0001, 4'b0100, 1'b1, 2'd2}, // 6 R9
        {4'b0001, 8'h22, 4'b1111, 4'b0100, 4'b0001, 4'b0000, 1'b0, 2'd0}, // 7 R9 R8
        {4'b0001, 8'h02, 4'b1111, 4'b0000, 4'b0001, 4'b0000, 1'b0, 2'd0}, // 8 R3
        {4'b0000, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b0001, 1'b1, 2'd0}, // 9 R11
        {4'b0000, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b0, 2'd0}, // 10 R9
        {4'b0000, 8'h08, 4'b1101, 4'b0000, 4'b0000, 4'b1111, 1'b0, 2'd0}, // 11 R7
        {4'b0001, 8'h0A, 4'b1111, 4'b0000, 4'b0001, 4'b0010, 1'b0, 2'd0}, // 12 R7
        {4'b0001, 8'h0A, 4'b1111, 4'b0000, 4'b0010, 4'b0001, 1'b1, 2'd0}, // 13 R4
        {4'b0000, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b0001, 1'b1, 2'd0}, // 14 R9
        {4'b0000, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b0, 2'd0}, // 15 R12
        {4'b1110, 8'hA8, 4'b1111, 4'b0000, 4'b1110, 4'b0000, 1'b0, 2'd0}, // 16 R2
        {4'b1110, 8'hA8, 4'b1111, 4'b0000, 4'b1100, 4'b0010, 1'b1, 2'd1}, // 17 R2
        {4'b1110, 8'h98, 4'b1111, 4'b0000, 4'b1000, 4'b0110, 1'b1, 2'd1}, // 18 R6
        {4'b1100, 8'hA0, 4'b1111, 4'b0000, 4'b1100, 4'b0010, 1'b1, 2'd1}, // 19 R10
        {4'b1100, 8'hA0, 4'b1111, 4'b0000, 4'b1100, 4'b0000, 1'b0, 2'd0}, // 20 R10
        {4'b1000, 8'h80, 4'b1111, 4'b0000, 4'b1000, 4'b0100, 1'b1, 2'd2}, // 21 R10
        {4'b1000, 8'h80, 4'b1111, 4'b0000, 4'b1000, 4'b0000, 1'b0, 2'd0}, // 22 R10
        {4'b1000, 8'h80, 4'b1111, 4'b0000, 4'b0000, 4'b1000, 1'b1, 2'd3}, // 23 R10
        {4'b0000, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b1000, 1'b1, 2'd3}, // 24 R9
        {4'b0000, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b0, 2'd0}  // 25 R12
    };

    function automatic string vtag(int i);
        case (i)
            0, 1, 15, 25:   return "R12";
            2:              return "R5";
            3, 8:           return "R3";
            4, 5, 13:       return "R4";
            6, 10, 14, 24:  return "R9";
            7:              return "R8";
            9:              return "R11";
            11, 12:         return "R7";
            16, 17:         return "R2";
            18:             return "R6";
            default:        return "R10";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        lock_req = '0; trans = '0; rdy = '1; inflight = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        drive_idle();
        #12;
        // R1: state while and right after reset
        check("R1", "owner_vld", int'(owner_vld), 0);
        check("R1", "stall", int'(stall), 0);
        check("R1", "permit", int'(permit), 'hF);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {lock_req, trans, rdy, inflight} = VEC[i][30:11];
            #1;
            check(vtag(i), $sformatf("stall v%0d", i), int'(stall), int'(VEC[i][10:7]));
            check(vtag(i), $sformatf("permit v%0d", i), int'(permit), int'(VEC[i][6:3]));
            check(vtag(i), $sformatf("owner_vld v%0d", i), int'(owner_vld), int'(VEC[i][2]));
            if (VEC[i][2])
                check(vtag(i), $sformatf("owner_idx v%0d", i), int'(owner_idx), int'(VEC[i][1:0]));
        end

        // R1: reset in the middle of a held lock clears ownership
        @(negedge clk);
        lock_req = 4'b0010; trans = 8'h08;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R4", "owner before reset", int'(owner_vld), 1);
        drive_idle();
        rst_n = 1'b0;
        #1;
        check("R1", "owner_vld in reset", int'(owner_vld), 0);
        check("R1", "stall in reset", int'(stall), 0);
        check("R1", "permit in reset", int'(permit), 'hF);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: in-flight master never stalled while a lock is pending
        @(negedge clk);
        lock_req = 4'b0001; trans = 8'h22; inflight = 4'b0100;
        #1;
        check("R8", "stall with inflight", int'(stall), 'h1);
        check("R3", "no grant while draining", int'(owner_vld), 0);
        @(negedge clk);
        #1;
        check("R3", "still no grant", int'(owner_vld), 0);
        drive_idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule